// File: doc/BRIEF.md
# Linked-Descriptor Linear Copy Engine

The engine copies blocks of bytes from one memory region to another. It takes its work from a chain of descriptors stored in memory, not from registers. Software writes a descriptor address and pulses start. The engine then reads the four-word descriptor, checks its control field, copies the byte count one 32-bit word at a time over a single word-addressed memory port, and marks the descriptor complete in memory. After that it follows the link to the next descriptor, and it stops when the link is zero.

Progress is visible on a status word, which carries the state and the current descriptor address. A fault stops the engine in the error state and records a syndrome: a valid bit, an 8-bit cause code and the byte address that caused it. A pause command stops a running engine at once and leaves it idle. Software treats this as a way to reset the engine.

Top module: `lindma_engine`

## Requirements
- R1: After reset, `stat_word` and `err_syn` and `err_addr` are all zero, and `mem_req` stays low until a start command arrives.
- R2: A start taken while the engine is idle or in error clears the low 4 bits of `cmd_addr` and sets the status state to running (code 1). The engine then reads descriptor words 0 to 3 at that aligned address plus 0, 4, 8 and 12. Word 0 is the link, word 1 is the control word, word 2 is the source and word 3 is the destination.
- R3: The control word's bits 23:0 give a byte length L. The engine reads ceil(L/4) words from source+4k and writes each one to destination+4k, with k counting up from 0, and ignores the low 2 address bits. Every write uses byte enables 4'b1111, except the last write when L mod 4 is not 0. That write enables only the lowest L mod 4 bytes, where `mem_be` bit i covers byte i.
- R4: A descriptor with L = 0 makes no data accesses and is still marked complete.
- R5: After a descriptor's copy, the engine writes to descriptor+4 the control word it read, with bit 31 set to 1 and all byte enables on.
- R6: The link's bits 31:4 give the next descriptor address, and its bits 3:0 are ignored. A zero link ends the chain with state idle (code 0), and `stat_word` still shows the last descriptor.
- R7: Control bits 25:24 must be 0, bits 27:26 (the compression selects) must be 0 and bits 29:28 (the bypass flags) must be 0. Bit 30 is accepted with no effect. On a violation the engine enters error (code 2) with `err_addr` equal to the descriptor address. The syndrome code is 2 for a bad type; otherwise it is 5 for compression and 4 for bypass, checked in that order. The engine writes no data and no completion bit for that descriptor.
- R8: A memory response with `mem_err` set stops the engine in error. The syndrome code is 7 for a descriptor read or completion write, 8 for a data read and 9 for a data write. `err_addr` is the byte address of the failing access, and no further access follows.
- R9: A start issued while running is ignored. A start that is taken clears `err_syn` and `err_addr` in the same clock edge that sets the state to running.
- R10: A pause while running moves the state to idle on the next edge, and no memory request follows. A pause in the error state leaves the error state unchanged.
- R11: `stat_word` carries the state in bits 1:0 (0 idle, 1 running, 2 error), zeros in bits 3:2 and the current descriptor address in bits 31:4. `err_syn` carries the valid bit in bit 0 and the code in bits 15:8, and all its other bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Start pulse; `cmd_addr` is taken with it |
| cmd_pause | input | 1 | Pause pulse; takes priority over start |
| cmd_addr | input | 32 | First descriptor address |
| stat_word | output | 32 | Descriptor address and state |
| err_syn | output | 32 | Syndrome valid bit and code |
| err_addr | output | 32 | Byte address of the fault |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Write byte enables |
| mem_ack | input | 1 | Request accepted this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_err | input | 1 | Access failed, valid with `mem_ack` |

## Verification
A behavioural model walks each chain over its own copy of memory and predicts every write: address, data and byte enables. The bench compares each write against that prediction as it happens, and the memory port stalls at pseudo-random points. The chains mix several lengths. A 10-byte copy and a 3-byte copy show whether the partial-word enables are right. A zero-length middle link shows that a completion bit is written with no data traffic. Links with stray low bits show the masking. Single descriptors with each bad field, and two bad fields together, separate the syndrome codes and show which one wins. Faulting addresses on a descriptor, a source, a destination and a link place the bus-error code on the right access. A long copy that is interrupted by a second start, and another that is interrupted by a pause, show the ignore and stop behaviour through the final memory image and the absence of later writes.

// File: rtl/lindma_engine.sv
module lindma_engine #(
  parameter int LEN_W = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_start,
  input  logic        cmd_pause,
  input  logic [31:0] cmd_addr,
  output logic [31:0] stat_word,
  output logic [31:0] err_syn,
  output logic [31:0] err_addr,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic [3:0]  mem_be,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  input  logic        mem_err
);
  localparam logic [LEN_W-1:0] WORD_BYTES = LEN_W'(4);

  typedef enum logic [3:0] {S_IDLE, S_LNK, S_CTL, S_SRC, S_DST, S_RD, S_WR, S_DONE, S_FAULT} st_t;

  st_t              st;
  logic [31:0]      desc_q, nxt_q, ctl_q, src_q, dst_q, buf_q;
  logic [LEN_W-1:0] rem_q;
  logic             syn_v;
  logic [7:0]       syn_c;
  logic [31:0]      syn_a;
  logic [7:0]       bus_code, fld_code;
  logic [1:0]       state_code;

  wire busy = (st != S_IDLE) && (st != S_FAULT);
  wire xfer = mem_req && mem_ack;
  wire last = rem_q <= WORD_BYTES;

  assign mem_req   = busy;
  assign mem_we    = (st == S_WR) || (st == S_DONE);
  assign mem_wdata = (st == S_DONE) ? (ctl_q | 32'h8000_0000) : buf_q;
  assign state_code = busy ? 2'd1 : (st == S_FAULT) ? 2'd2 : 2'd0;
  assign stat_word = {desc_q[31:4], 2'b00, state_code};
  assign err_syn   = {16'h0, syn_c, 7'h0, syn_v};
  assign err_addr  = syn_a;

  always_comb begin
    case (st)
      S_LNK:   mem_addr = desc_q;
      S_CTL:   mem_addr = desc_q + 32'd4;
      S_SRC:   mem_addr = desc_q + 32'd8;
      S_DST:   mem_addr = desc_q + 32'd12;
      S_RD:    mem_addr = src_q;
      S_WR:    mem_addr = dst_q;
      S_DONE:  mem_addr = desc_q + 32'd4;
      default: mem_addr = 32'h0;
    endcase
  end

  always_comb begin
    mem_be = 4'hF;
    if (st == S_WR && rem_q < WORD_BYTES) begin
      case (rem_q[1:0])
        2'd1:    mem_be = 4'b0001;
        2'd2:    mem_be = 4'b0011;
        default: mem_be = 4'b0111;
      endcase
    end
  end

  always_comb begin
    case (st)
      S_RD:    bus_code = 8'd8;
      S_WR:    bus_code = 8'd9;
      default: bus_code = 8'd7;
    endcase
    if (mem_rdata[25:24] != 2'b00)      fld_code = 8'd2;
    else if (mem_rdata[27:26] != 2'b00) fld_code = 8'd5;
    else if (mem_rdata[29:28] != 2'b00) fld_code = 8'd4;
    else                                fld_code = 8'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      desc_q <= '0; nxt_q <= '0; ctl_q <= '0; src_q <= '0; dst_q <= '0; buf_q <= '0;
      rem_q <= '0; syn_v <= 1'b0; syn_c <= '0; syn_a <= '0;
    end else if (cmd_pause && busy) begin
      st <= S_IDLE;
    end else if (cmd_start && !busy) begin
      st <= S_LNK;
      desc_q <= cmd_addr & ~32'hF;
      syn_v <= 1'b0; syn_c <= '0; syn_a <= '0;
    end else if (xfer) begin
      if (mem_err) begin
        st <= S_FAULT; syn_v <= 1'b1; syn_c <= bus_code; syn_a <= mem_addr;
      end else begin
        case (st)
          S_LNK: begin nxt_q <= mem_rdata & ~32'hF; st <= S_CTL; end
          S_CTL: begin
            ctl_q <= mem_rdata;
            rem_q <= mem_rdata[LEN_W-1:0];
            if (fld_code != 8'd0) begin
              st <= S_FAULT; syn_v <= 1'b1; syn_c <= fld_code; syn_a <= desc_q;
            end else st <= S_SRC;
          end
          S_SRC: begin src_q <= mem_rdata & ~32'h3; st <= S_DST; end
          S_DST: begin
            dst_q <= mem_rdata & ~32'h3;
            st <= (rem_q == '0) ? S_DONE : S_RD;
          end
          S_RD: begin buf_q <= mem_rdata; st <= S_WR; end
          S_WR: begin
            src_q <= src_q + 32'd4;
            dst_q <= dst_q + 32'd4;
            rem_q <= last ? '0 : rem_q - WORD_BYTES;
            st <= last ? S_DONE : S_RD;
          end
          S_DONE: begin
            if (nxt_q == 32'h0) st <= S_IDLE;
            else begin desc_q <= nxt_q; st <= S_LNK; end
          end
          default: st <= st;
        endcase
      end
    end
  end

  a_r1_quiet_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_word[1:0] != 2'd1) |-> !mem_req);
  a_r3_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));
  a_r3_enables_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_be != 4'h0));
  a_r7_fault_has_syndrome: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_word[1:0] == 2'd2) |-> err_syn[0]);
  a_r8_request_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !cmd_pause) |=> (mem_req && $stable(mem_addr)));
  a_r9_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && !cmd_pause && stat_word[1:0] != 2'd1) |=> (!err_syn[0] && stat_word[1:0] == 2'd1));
  a_r10_pause_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_pause && stat_word[1:0] == 2'd1) |=> (stat_word[1:0] == 2'd0));
endmodule

// File: tb/tb_lindma_engine.sv
module tb_lindma_engine;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] HOLE = 32'h400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        cmd_start = 1'b0, cmd_pause = 1'b0;
  logic [31:0] cmd_addr = '0;
  logic [31:0] stat_word, err_syn, err_addr, mem_addr, mem_wdata, mem_rdata;
  logic        mem_req, mem_we, mem_ack, mem_err;
  logic [3:0]  mem_be;
  logic [7:0]  lfsr;

  lindma_engine dut (.clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_pause(cmd_pause),
    .cmd_addr(cmd_addr), .stat_word(stat_word), .err_syn(err_syn), .err_addr(err_addr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_be(mem_be), .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_err(mem_err));

  logic [31:0] bm [256];
  logic [31:0] mm [256];
  logic [31:0] qa[$], qd[$];
  logic [3:0]  qb[$];
  int n_cmp = 0, n_bad = 0;
  bit quiet = 0;
  logic [1:0]  e_st;
  logic [31:0] e_desc, e_syn, e_ea;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) lfsr <= 8'h5A;
    else lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};

  assign mem_ack   = mem_req && !(lfsr[0] && lfsr[2]);
  assign mem_err   = mem_addr >= HOLE;
  assign mem_rdata = mem_err ? 32'hDEAD_BEEF : bm[mem_addr[9:2]];

  always @(posedge clk)
    if (mem_req && mem_ack && mem_we && !mem_err)
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) bm[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk)
    if (rst_n && mem_req && mem_ack && mem_we) begin
      if (quiet) chk("R10 write after pause", mem_addr, 32'hFFFF_FFFF);
      else if (qa.size() == 0) chk("R3/R5 unexpected write", mem_addr, 32'hFFFF_FFFF);
      else begin
        chk("R3/R5 write address", mem_addr, qa.pop_front());
        chk("R3/R5 write data", mem_wdata, qd.pop_front());
        chk("R3 write enables", {28'h0, mem_be}, {28'h0, qb.pop_front()});
      end
    end

  task automatic fault(input logic [7:0] code, input logic [31:0] a);
    e_st = 2'd2; e_syn = {16'h0, code, 8'h01}; e_ea = a;
  endtask

  task automatic model(input logic [31:0] sa);
    logic [31:0] p, w0, w1, s, d, v;
    logic [3:0] be;
    int len;
    bit bad;
    p = sa & ~32'hF;
    e_st = 2'd0; e_syn = '0; e_ea = '0;
    for (int hop = 0; hop < 16; hop++) begin
      e_desc = p;
      if (p >= HOLE) begin fault(8'd7, p); break; end
      w0 = mm[p[9:2]]; w1 = mm[p[9:2] + 8'd1];
      s = mm[p[9:2] + 8'd2] & ~32'h3; d = mm[p[9:2] + 8'd3] & ~32'h3;
      if (w1[25:24] != 0) begin fault(8'd2, p); break; end
      if (w1[27:26] != 0) begin fault(8'd5, p); break; end
      if (w1[29:28] != 0) begin fault(8'd4, p); break; end
      len = int'(w1[23:0]); bad = 0;
      while (len > 0) begin
        if (s >= HOLE) begin fault(8'd8, s); bad = 1; break; end
        v = mm[s[9:2]];
        be = (len >= 4) ? 4'hF : (len == 3) ? 4'h7 : (len == 2) ? 4'h3 : 4'h1;
        qa.push_back(d); qd.push_back(v); qb.push_back(be);
        if (d >= HOLE) begin fault(8'd9, d); bad = 1; break; end
        for (int b = 0; b < 4; b++) if (be[b]) mm[d[9:2]][8*b +: 8] = v[8*b +: 8];
        s += 4; d += 4; len = (len >= 4) ? len - 4 : 0;
      end
      if (bad) break;
      qa.push_back(p + 4); qd.push_back(w1 | 32'h8000_0000); qb.push_back(4'hF);
      mm[p[9:2] + 8'd1] = w1 | 32'h8000_0000;
      if ((w0 & ~32'hF) == 0) break;
      p = w0 & ~32'hF;
    end
  endtask

  task automatic fill(input logic [31:0] seed);
    for (int i = 0; i < 256; i++) begin
      bm[i] = (i * 32'h0103_0507) ^ seed;
      mm[i] = bm[i];
    end
  endtask

  task automatic desc(input logic [31:0] a, input logic [31:0] nx, input logic [31:0] ctl,
                      input logic [31:0] s, input logic [31:0] d);
    bm[a[9:2]] = nx; bm[a[9:2] + 8'd1] = ctl; bm[a[9:2] + 8'd2] = s; bm[a[9:2] + 8'd3] = d;
    mm[a[9:2]] = nx; mm[a[9:2] + 8'd1] = ctl; mm[a[9:2] + 8'd2] = s; mm[a[9:2] + 8'd3] = d;
  endtask

  task automatic go(input logic [31:0] a);
    @(negedge clk); cmd_addr = a; cmd_start = 1'b1;
    @(negedge clk); cmd_start = 1'b0;
  endtask

  task automatic finish_and_check(input string req);
    int first;
    for (int i = 0; i < 20000 && stat_word[1:0] == 2'd1; i++) @(negedge clk);
    chk({req, " state"}, {30'h0, stat_word[1:0]}, {30'h0, e_st});
    chk({req, " R11 descriptor field"}, stat_word & ~32'h3, e_desc);
    chk({req, " syndrome"}, err_syn, e_syn);
    chk({req, " fault address"}, err_addr, e_ea);
    chk({req, " writes left"}, qa.size(), 0);
    first = -1;
    for (int i = 0; i < 256; i++) if (first < 0 && bm[i] !== mm[i]) first = i;
    if (first < 0) chk({req, " memory image"}, 0, 0);
    else chk({req, " memory image"}, bm[first], mm[first]);
    qa.delete(); qd.delete(); qb.delete();
  endtask

  task automatic run(input logic [31:0] sa, input string req);
    model(sa);
    go(sa);
    chk({req, " R9 syndrome cleared on start"}, err_syn, 32'h0);
    finish_and_check(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk("watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 status after reset", stat_word, 32'h0);
    chk("R1 syndrome after reset", err_syn, 32'h0);
    chk("R1 fault address after reset", err_addr, 32'h0);
    chk("R1 no request after reset", {31'h0, mem_req}, 32'h0);

    fill(32'h1111_0000);
    desc(32'h040, 32'h0, 32'h4000_000A, 32'h100, 32'h200);
    run(32'h047, "R2 R3 R5 ten bytes");

    fill(32'h2222_0000);
    desc(32'h000, 32'h039, 32'h0000_0008, 32'h100, 32'h200);
    desc(32'h030, 32'h06F, 32'h0000_0000, 32'h3FC, 32'h3FC);
    desc(32'h060, 32'h0,   32'h0000_0003, 32'h122, 32'h2F1);
    run(32'h000, "R4 R6 chain");

    fill(32'h3333_0000);
    desc(32'h080, 32'h0, 32'h0100_0004, 32'h100, 32'h200);
    run(32'h080, "R7 type code 2");
    desc(32'h080, 32'h0, 32'h1800_0004, 32'h100, 32'h200);
    run(32'h080, "R7 compression over bypass code 5");
    desc(32'h080, 32'h0, 32'h2000_0004, 32'h100, 32'h200);
    run(32'h080, "R7 bypass code 4");
    desc(32'h080, 32'h0, 32'h0600_0004, 32'h100, 32'h200);
    run(32'h080, "R7 type over compression code 2");
    @(negedge clk); cmd_pause = 1'b1; @(negedge clk); cmd_pause = 1'b0;
    chk("R10 pause keeps error", {30'h0, stat_word[1:0]}, 32'd2);

    fill(32'h4444_0000);
    desc(32'h000, 32'h0, 32'h0000_0008, 32'h500, 32'h200);
    run(32'h000, "R8 data read code 8");
    desc(32'h000, 32'h0, 32'h0000_0006, 32'h100, 32'h480);
    run(32'h000, "R8 data write code 9");
    run(32'h800, "R8 descriptor read code 7");
    desc(32'h000, 32'h418, 32'h0000_0004, 32'h100, 32'h200);
    run(32'h000, "R8 link into hole code 7");

    fill(32'h5555_0000);
    desc(32'h000, 32'h0, 32'h0000_00C8, 32'h100, 32'h200);
    desc(32'h040, 32'h0, 32'h0000_0004, 32'h100, 32'h300);
    model(32'h000);
    go(32'h000);
    repeat (20) @(negedge clk);
    go(32'h040);
    finish_and_check("R9 start while running ignored");

    fill(32'h6666_0000);
    desc(32'h000, 32'h0, 32'h0000_00C8, 32'h100, 32'h200);
    model(32'h000);
    go(32'h000);
    repeat (30) @(negedge clk);
    cmd_pause = 1'b1; @(negedge clk); cmd_pause = 1'b0;
    chk("R10 pause to idle", {30'h0, stat_word[1:0]}, 32'd0);
    quiet = 1; qa.delete(); qd.delete(); qb.delete();
    repeat (30) @(negedge clk);
    chk("R10 no request after pause", {31'h0, mem_req}, 32'h0);
    chk("R10 syndrome clear after pause", err_syn, 32'h0);
    quiet = 0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule